// File: doc/BRIEF.md
# Indirectly Addressed Scaler Counter Bank

This block holds a bank of 64-bit event counters arranged as six groups of eight channels. Software never addresses a counter directly. It first writes a group code, a channel number and a word index into three small select registers. A read of the data window then returns one 16-bit slice of the chosen counter. Separate data-less write offsets act as commands. They bump the chosen counter, zero it, zero the whole bank, or copy every counter into a shadow bank in the same cycle.

Each counter also advances on its own external hit line. Hit line `k` belongs to group code `0x12 + k/8` and channel `k%8`. While a shadow copy taken since the last clear exists, reads come from the shadow bank, so software gets a coherent picture of all channels. Read results appear on `bus_rdata` one cycle after the read strobe and hold until the next read.

Top module: `scaler_bank`

## Requirements
- R1: Writes to 0x04, 0x08 and 0x1C load the group code (wdata[4:0]), the channel (wdata[2:0]) and the word index (wdata[1:0]). Reading the same offset returns the value zero-extended on `bus_rdata` in the cycle after the strobe.
- R2: A read of 0x20 returns the selected counter's slice for word index w, bits [16w+15:16w] (w=0 gives 15:0 and w=3 gives 63:48), zero-extended to 32 bits.
- R3: Each clock cycle with hit[k] high adds one to counter k, whose group code is 0x12+k/8 and whose channel is k%8.
- R4: A write to 0x24 adds one to the selected counter whatever the write data.
- R5: A hit and a 0x24 write to the same counter in one cycle add two.
- R6: A write to 0x28 zeroes only the selected counter. A clear wins over a hit or increment in the same cycle.
- R7: A write to 0x2C or to 0x48 zeroes every counter.
- R8: A write to 0x4C copies all counters into the shadow bank at once. From then on, 0x20 reads come from the shadow bank until the next clear command (0x28, 0x2C or 0x48). Until then they show the live value.
- R9: With a group code outside 0x12..0x17, a 0x20 read returns zero and 0x24/0x28 writes change nothing.
- R10: After reset the select registers, counters, shadow bank, shadow flag and `bus_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Registered read result |
| hit | input | 48 | One event line per counter |

## Verification
The in-RTL assertions check several rules on every cycle:
- a clear leaves the counter at zero the next cycle, whatever else arrived;
- a counter never advances by more than two per cycle;
- a capture copies the exact pre-edge value;
- command decodes are mutually exclusive and are gated off for an unknown group code;
- select registers read back, and unknown-group reads return zero.

Only the bench scenarios show the rest, using a behavioural model compared every clock:
- that the group/channel pair reaches the right counter and leaves its neighbours untouched;
- that the shadow flag is released by each clear command;
- that the upper slices carry the count past 16 bits.

// File: rtl/scaler_pkg.sv
package scaler_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CHIP_W = 5;
    localparam int CHAN_W = 3;
    localparam int WSEL_W = 2;
    localparam int WORD_W = 16;

    localparam logic [7:0] OFF_CHIP    = 8'h04;
    localparam logic [7:0] OFF_CHAN    = 8'h08;
    localparam logic [7:0] OFF_WSEL    = 8'h1C;
    localparam logic [7:0] OFF_WORD    = 8'h20;
    localparam logic [7:0] OFF_INC     = 8'h24;
    localparam logic [7:0] OFF_CLR     = 8'h28;
    localparam logic [7:0] OFF_CLR_ALL = 8'h2C;
    localparam logic [7:0] OFF_RESET   = 8'h48;
    localparam logic [7:0] OFF_SNAP    = 8'h4C;

    typedef struct packed {
        logic [CHIP_W-1:0] chip;
        logic [CHAN_W-1:0] chan;
        logic [WSEL_W-1:0] wsel;
    } sel_regs_t;
endpackage

// File: rtl/scaler_cmd_dec.sv
module scaler_cmd_dec
    import scaler_pkg::*;
#(
    parameter int N_GROUPS  = 6,
    parameter int CHIP_BASE = 18,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    output sel_regs_t         sel_q,
    output logic              sel_valid,
    output logic [IDX_W-1:0]  sel_idx,
    output logic              cmd_inc,
    output logic              cmd_clr,
    output logic              cmd_clr_all,
    output logic              cmd_snap
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N_CHAN = 1 << CHAN_W;

    sel_regs_t sel_d;

    always_comb begin
        sel_d = sel_q;
        if (bus_wr) begin
            if (bus_addr == ADDR_W'(OFF_CHIP)) sel_d.chip = bus_wdata[CHIP_W-1:0];
            if (bus_addr == ADDR_W'(OFF_CHAN)) sel_d.chan = bus_wdata[CHAN_W-1:0];
            if (bus_addr == ADDR_W'(OFF_WSEL)) sel_d.wsel = bus_wdata[WSEL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    always_comb begin
        int grp;
        grp         = int'(sel_q.chip) - CHIP_BASE;
        sel_valid   = (grp >= 0) && (grp < N_GROUPS);
        sel_idx     = sel_valid ? IDX_W'(grp * N_CHAN + int'(sel_q.chan)) : '0;
        cmd_inc     = bus_wr && sel_valid && (bus_addr == ADDR_W'(OFF_INC));
        cmd_clr     = bus_wr && sel_valid && (bus_addr == ADDR_W'(OFF_CLR));
        cmd_clr_all = bus_wr && ((bus_addr == ADDR_W'(OFF_CLR_ALL)) ||
                                 (bus_addr == ADDR_W'(OFF_RESET)));
        cmd_snap    = bus_wr && (bus_addr == ADDR_W'(OFF_SNAP));
    end

    // R4: at most one command per bus cycle
    a_r4_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_inc, cmd_clr, cmd_clr_all, cmd_snap}));

    // R9: unknown group never yields a per-counter command
    a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> (!cmd_inc && !cmd_clr));
endmodule

// File: rtl/scaler_cell.sv
module scaler_cell #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             inc,
    input  logic             clr,
    input  logic             snap,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] snap_q
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] snap_d;

    always_comb begin
        snap_d = snap ? cnt_q : snap_q;
        if (clr) cnt_d = '0;
        else     cnt_d = cnt_q + CNT_W'(hit) + CNT_W'(inc);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            snap_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            snap_q <= snap_d;
        end
    end

    // R6: clear wins over any same-cycle increment
    a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    // R5: advance never exceeds two per cycle
    a_r5_step_max: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((cnt_q - $past(cnt_q)) <= CNT_W'(2)));

    // R8: capture takes the pre-edge count
    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (snap_q == $past(cnt_q)));
endmodule

// File: rtl/scaler_bank.sv
module scaler_bank
    import scaler_pkg::*;
#(
    parameter int N_GROUPS  = 6,
    parameter int CNT_W     = 64,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int CHIP_BASE = 18
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [DATA_W-1:0]                 bus_wdata,
    input  logic                              bus_wr,
    input  logic                              bus_rd,
    output logic [DATA_W-1:0]                 bus_rdata,
    input  logic [N_GROUPS*(1<<CHAN_W)-1:0]   hit
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N_CHAN = 1 << CHAN_W;
    localparam int N_CNT  = N_GROUPS * N_CHAN;
    localparam int IDX_W  = $clog2(N_CNT);

    sel_regs_t        sel_q;
    logic             sel_valid;
    logic [IDX_W-1:0] sel_idx;
    logic             cmd_inc, cmd_clr, cmd_clr_all, cmd_snap;

    logic [CNT_W-1:0] live_all [N_CNT];
    logic [CNT_W-1:0] shad_all [N_CNT];

    logic              shad_ok_d, shad_ok_q;
    logic [DATA_W-1:0] rdata_d, rdata_q;

    scaler_cmd_dec #(
        .N_GROUPS (N_GROUPS),
        .CHIP_BASE(CHIP_BASE),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .sel_q      (sel_q),
        .sel_valid  (sel_valid),
        .sel_idx    (sel_idx),
        .cmd_inc    (cmd_inc),
        .cmd_clr    (cmd_clr),
        .cmd_clr_all(cmd_clr_all),
        .cmd_snap   (cmd_snap)
    );

    for (genvar i = 0; i < N_CNT; i++) begin : g_cell
        logic here;
        assign here = (sel_idx == IDX_W'(i));
        scaler_cell #(.CNT_W(CNT_W)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit[i]),
            .inc   (cmd_inc && here),
            .clr   (cmd_clr_all || (cmd_clr && here)),
            .snap  (cmd_snap),
            .cnt_q (live_all[i]),
            .snap_q(shad_all[i])
        );
    end

    always_comb begin
        logic [CNT_W-1:0] src;
        src       = shad_ok_q ? shad_all[sel_idx] : live_all[sel_idx];
        shad_ok_d = shad_ok_q;
        if (cmd_snap)              shad_ok_d = 1'b1;
        if (cmd_clr || cmd_clr_all) shad_ok_d = 1'b0;
        rdata_d = rdata_q;
        if (bus_rd) begin
            rdata_d = '0;
            if (bus_addr == ADDR_W'(OFF_CHIP)) rdata_d = DATA_W'(sel_q.chip);
            if (bus_addr == ADDR_W'(OFF_CHAN)) rdata_d = DATA_W'(sel_q.chan);
            if (bus_addr == ADDR_W'(OFF_WSEL)) rdata_d = DATA_W'(sel_q.wsel);
            if (bus_addr == ADDR_W'(OFF_WORD) && sel_valid)
                rdata_d = DATA_W'(src[int'(sel_q.wsel)*WORD_W +: WORD_W]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shad_ok_q <= 1'b0;
            rdata_q   <= '0;
        end else begin
            shad_ok_q <= shad_ok_d;
            rdata_q   <= rdata_d;
        end
    end

    assign bus_rdata = rdata_q;

    // R9: unknown group reads as zero
    a_r9_invalid_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFF_WORD) && !sel_valid) |=> (bus_rdata == '0));

    // R1: group code reads back
    a_r1_chip_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFF_CHIP)) |=> (bus_rdata == DATA_W'($past(sel_q.chip))));

    // R8: capture raises the shadow flag
    a_r8_flag: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_snap |=> shad_ok_q);

    // R7: bank clear drops the shadow flag
    a_r7_flag_drop: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_clr_all |=> !shad_ok_q);
endmodule

// File: tb/sim_scaler_bank.sv
module sim_scaler_bank;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic        bus_wr = 0;
    logic        bus_rd = 0;
    logic [31:0] bus_rdata;
    logic [47:0] hit = 0;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string cur_req = "R10";

    always #4 clk = ~clk; // 125 MHz

    scaler_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .hit(hit)
    );

    // behavioural reference model
    logic [63:0] m_cnt [48];
    logic [63:0] m_shad [48];
    logic [4:0]  m_chip;
    logic [2:0]  m_chan;
    logic [1:0]  m_wsel;
    logic        m_sok;
    logic [31:0] m_rdata;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_cnt[i]) begin m_cnt[i] = 0; m_shad[i] = 0; end
            m_chip = 0; m_chan = 0; m_wsel = 0; m_sok = 0; m_rdata = 0;
        end else begin
            int g;
            bit ok;
            int k;
            logic [63:0] v;
            g  = int'(m_chip) - 18;
            ok = (g >= 0) && (g < 6);
            k  = ok ? g * 8 + int'(m_chan) : 0;
            if (bus_rd) begin
                m_rdata = 0;
                case (bus_addr)
                    8'h04: m_rdata = {27'd0, m_chip};
                    8'h08: m_rdata = {29'd0, m_chan};
                    8'h1C: m_rdata = {30'd0, m_wsel};
                    8'h20: if (ok) begin
                        v = m_sok ? m_shad[k] : m_cnt[k];
                        m_rdata = 32'((v >> (16 * m_wsel)) & 64'hFFFF);
                    end
                    default: ;
                endcase
            end
            if (bus_wr && bus_addr == 8'h4C) foreach (m_shad[i]) m_shad[i] = m_cnt[i];
            foreach (m_cnt[i]) begin
                if ((bus_wr && (bus_addr == 8'h2C || bus_addr == 8'h48)) ||
                    (bus_wr && bus_addr == 8'h28 && ok && k == i))
                    m_cnt[i] = 0;
                else
                    m_cnt[i] = m_cnt[i] + 64'(hit[i]) +
                               64'(bus_wr && bus_addr == 8'h24 && ok && k == i);
            end
            if (bus_wr && bus_addr == 8'h4C) m_sok = 1;
            if (bus_wr && (bus_addr == 8'h2C || bus_addr == 8'h48 ||
                           (bus_addr == 8'h28 && ok))) m_sok = 0;
            if (bus_wr && bus_addr == 8'h04) m_chip = bus_wdata[4:0];
            if (bus_wr && bus_addr == 8'h08) m_chan = bus_wdata[2:0];
            if (bus_wr && bus_addr == 8'h1C) m_wsel = bus_wdata[1:0];
        end
        #1;
        checks++;
        if (bus_rdata !== m_rdata) begin
            failures++;
            $display("FAIL %s model compare: actual=%h expected=%h", cur_req, bus_rdata, m_rdata);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a);
        bus_addr = a; bus_rd = 1;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic expect_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        rd(a);
        checks++;
        if (bus_rdata !== exp) begin
            failures++;
            $display("FAIL %s read %h: actual=%h expected=%h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic sel(input logic [4:0] c, input logic [2:0] ch);
        wr(8'h04, {27'd0, c});
        wr(8'h08, {29'd0, ch});
    endtask

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        cur_req = "R10";
        expect_rd("R10", 8'h04, 0);
        expect_rd("R10", 8'h20, 0);

        cur_req = "R1";
        wr(8'h04, 32'hFFFF_FFF2);
        expect_rd("R1", 8'h04, 32'h12);
        wr(8'h08, 32'hABCD_0005);
        expect_rd("R1", 8'h08, 5);
        wr(8'h1C, 7);
        expect_rd("R1", 8'h1C, 3);
        wr(8'h1C, 0);

        cur_req = "R4";
        repeat (3) wr(8'h24, 32'hDEAD_BEEF);
        expect_rd("R4", 8'h20, 3);

        cur_req = "R3";
        sel(5'h13, 2);
        hit[10] = 1;
        repeat (4) @(negedge clk);
        hit[10] = 0;
        expect_rd("R3", 8'h20, 4);

        cur_req = "R5";
        hit[10] = 1;
        wr(8'h24, 0);
        hit[10] = 0;
        expect_rd("R5", 8'h20, 6);

        cur_req = "R6";
        sel(5'h12, 5);
        hit[5] = 1;
        wr(8'h28, 0);
        hit[5] = 0;
        expect_rd("R6", 8'h20, 0);
        sel(5'h13, 2);
        expect_rd("R6", 8'h20, 6);

        cur_req = "R9";
        sel(5'h11, 0);
        wr(8'h24, 0);
        expect_rd("R9", 8'h20, 0);
        sel(5'h18, 7);
        wr(8'h24, 0);
        wr(8'h28, 0);
        expect_rd("R9", 8'h20, 0);
        sel(5'h12, 0);
        expect_rd("R9", 8'h20, 0);
        sel(5'h17, 7);
        expect_rd("R9", 8'h20, 0);

        cur_req = "R8";
        sel(5'h13, 2);
        wr(8'h4C, 0);
        wr(8'h24, 0);
        wr(8'h24, 0);
        expect_rd("R8", 8'h20, 6);

        cur_req = "R7";
        wr(8'h2C, 0);
        expect_rd("R7", 8'h20, 0);
        wr(8'h24, 0);
        wr(8'h4C, 0);
        wr(8'h24, 0);
        expect_rd("R8", 8'h20, 1);
        wr(8'h48, 0);
        expect_rd("R7", 8'h20, 0);

        cur_req = "R2";
        sel(5'h14, 1);
        hit[17] = 1;
        repeat (70000) @(negedge clk);
        hit[17] = 0;
        expect_rd("R2", 8'h20, 32'h1170);
        wr(8'h1C, 1);
        expect_rd("R2", 8'h20, 1);
        wr(8'h1C, 2);
        expect_rd("R2", 8'h20, 0);
        wr(8'h1C, 3);
        expect_rd("R2", 8'h20, 0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule